// File: doc/BRIEF.md
# Eight-bit microcontroller ALU

A purely combinational arithmetic-logic unit for a small register-file microcontroller core. It takes a destination operand, the byte above it for register-pair operations, a source register operand, an immediate, a carry-in and a five-bit operation code. It returns the new destination byte, the new upper byte, a carry-out, zero and negative flags, and a write-enable telling the register file whether to store the result.

The operation set covers add and subtract with and without carry, bitwise AND/OR/XOR, one's and two's complement, mask-driven bit set and bit clear, increment, decrement, test, clear, set-all, single-bit shifts and rotates through carry, 16-bit add and subtract of a small immediate on a register pair, and compare forms that compute a difference without writing it back. Decode, storage, multiplication and the full status rules are left to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Op codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 COM, 8 NEG, 9 SBR, 10 CBR, 11 INC, 12 DEC, 13 TST, 14 CLR, 15 SER, 16 LSL, 17 LSR, 18 ROL, 19 ROR, 20 ASR, 21 ADW, 22 SBW, 23 CP, 24 CPC; ADD gives a+s and ADC gives a+s+carry_i, with carry_o the unsigned carry out of bit 7.
- R2: SUB gives a−s and SBC gives a−s−carry_i modulo 256, with carry_o set when a borrow occurs.
- R3: The second operand s is imm_i when use_imm_i is 1 and b_i otherwise, for every byte operation that has a second operand (ADD, ADC, SUB, SBC, AND, OR, XOR, SBR, CBR, CP, CPC).
- R4: COM gives 0xFF−a with carry_o 0; NEG gives 0x00−a with carry_o set exactly when a is non-zero.
- R5: AND, OR, XOR give the bitwise result of a and s; SBR gives a OR s and CBR gives a AND (0xFF−s); carry_o equals carry_i.
- R6: TST returns a unchanged, CLR returns 0x00, SER returns 0xFF; carry_o equals carry_i.
- R7: INC gives a+1 and DEC gives a−1 modulo 256, leaving carry_o equal to carry_i.
- R8: LSL shifts left filling 0, LSR shifts right filling 0, ROL fills bit 0 from carry_i, ROR fills bit 7 from carry_i, ASR keeps bit 7; carry_o is the bit shifted out.
- R9: ADW and SBW add or subtract the low 6 bits of imm_i, zero-extended, to the 16-bit value {a_hi_i, a_i}; the result appears on {result_hi_o, result_o}, carry_o is the carry or borrow out of bit 15, zero_o covers all 16 bits and neg_o is bit 15.
- R10: CP and CPC present the SUB and SBC results and flags but hold wr_en_o at 0; every other listed operation drives wr_en_o to 1.
- R11: For byte operations zero_o is set exactly when result_o is 0x00 and neg_o equals result_o bit 7.
- R12: For byte operations result_hi_o equals a_hi_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Destination operand (low byte of a pair) |
| a_hi_i | input | 8 | Next register up, high byte for pair operations |
| b_i | input | 8 | Source register operand |
| imm_i | input | 8 | Immediate operand |
| use_imm_i | input | 1 | Select imm_i as second operand |
| carry_i | input | 1 | Carry-in |
| op_i | input | 5 | Operation code |
| result_o | output | 8 | Result byte (low byte for pair operations) |
| result_hi_o | output | 8 | High byte of the pair result |
| carry_o | output | 1 | Carry, borrow or shifted-out bit |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result sign bit |
| wr_en_o | output | 1 | Result should be written back |

## Verification
The bench builds the unit with its defaults, an 8-bit data path and a 6-bit pair immediate. At that width every operation can be swept against the corner bytes 0x00, 0x7F, 0x80 and 0xFF on both operands with carry-in 0 and 1 and both operand sources, so carry and borrow at the wrap points, sign-bit shifts and the 16-bit carry across the byte boundary are all reached, with random operands on top.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7,
    OP_NEG = 5'd8,  OP_SBR = 5'd9,  OP_CBR = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_TST = 5'd13, OP_CLR = 5'd14, OP_SER = 5'd15,
    OP_LSL = 5'd16, OP_LSR = 5'd17, OP_ROL = 5'd18, OP_ROR = 5'd19,
    OP_ASR = 5'd20, OP_ADW = 5'd21, OP_SBW = 5'd22, OP_CP  = 5'd23,
    OP_CPC = 5'd24
  } alu_op_e;

  typedef enum logic [2:0] {
    GRP_ARITH, GRP_STEP, GRP_LOGIC, GRP_SHIFT, GRP_WORD, GRP_NONE
  } alu_grp_e;

  function automatic alu_grp_e op_group(input logic [OP_W-1:0] code);
    case (code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_COM, OP_NEG, OP_CP, OP_CPC:    return GRP_ARITH;
      OP_INC, OP_DEC:                   return GRP_STEP;
      OP_AND, OP_OR, OP_XOR, OP_SBR,
      OP_CBR, OP_TST, OP_CLR, OP_SER:   return GRP_LOGIC;
      OP_LSL, OP_LSR, OP_ROL, OP_ROR,
      OP_ASR:                           return GRP_SHIFT;
      OP_ADW, OP_SBW:                   return GRP_WORD;
      default:                          return GRP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam logic [W:0] CIN_PAD = '0;

  logic [W:0]   ext;
  logic [W:0]   cin_ext;
  logic [W-1:0] back;

  assign cin_ext = CIN_PAD | {{W{1'b0}}, cin_i};

  always_comb begin
    if (sub_i) ext = {1'b0, x_i} - {1'b0, y_i} - cin_ext;
    else       ext = {1'b0, x_i} + {1'b0, y_i} + cin_ext;
  end

  assign sum_o  = ext[W-1:0];
  assign cout_o = ext[W];

  // inverse operation recovers x
  assign back = sub_i ? (sum_o + y_i + cin_ext[W-1:0]) : (sum_o - y_i - cin_ext[W-1:0]);

  always_comb begin
    if (!$isunknown({x_i, y_i, cin_i, sub_i})) begin
      a_r2_inverse_ok: assert (back == x_i)
        else $error("addsub inverse mismatch");
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    s_i,
  output logic [W-1:0]    res_o
);
  always_comb begin
    case (op_i)
      OP_AND:         res_o = a_i & s_i;
      OP_OR, OP_SBR:  res_o = a_i | s_i;
      OP_XOR:         res_o = a_i ^ s_i;
      OP_CBR:         res_o = a_i & ({W{1'b1}} - s_i);
      OP_TST:         res_o = a_i & a_i;
      OP_CLR:         res_o = a_i ^ a_i;
      OP_SER:         res_o = {W{1'b1}};
      default:        res_o = a_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, s_i}) && op_i == OP_CBR) begin
      a_r5_cbr_clears: assert ((res_o & s_i) == '0 && (res_o | s_i) == (a_i | s_i))
        else $error("bit clear left masked bits set");
    end
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic            cin_i,
  output logic [W-1:0]    res_o,
  output logic            cout_o
);
  always_comb begin
    res_o  = a_i;
    cout_o = cin_i;
    case (op_i)
      OP_LSL: begin res_o = {a_i[W-2:0], 1'b0};     cout_o = a_i[W-1]; end
      OP_LSR: begin res_o = {1'b0, a_i[W-1:1]};     cout_o = a_i[0];   end
      OP_ROL: begin res_o = {a_i[W-2:0], cin_i};    cout_o = a_i[W-1]; end
      OP_ROR: begin res_o = {cin_i, a_i[W-1:1]};    cout_o = a_i[0];   end
      OP_ASR: begin res_o = {a_i[W-1], a_i[W-1:1]}; cout_o = a_i[0];   end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, cin_i}) && op_i == OP_ASR) begin
      a_r8_asr_sign: assert (res_o[W-1] == a_i[W-1] && res_o[W-2] == a_i[W-1])
        else $error("arithmetic shift lost sign");
    end
    if (!$isunknown({op_i, a_i, cin_i}) && (op_i == OP_ROL || op_i == OP_ROR)) begin
      a_r8_rotate_bits: assert ($countones({res_o, cout_o}) == $countones({a_i, cin_i}))
        else $error("rotate changed bit population");
    end
  end
endmodule

// File: rtl/alu8_word.sv
module alu8_word #(
  parameter int W      = 8,
  parameter int IMM_W  = 6
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] imm_i,
  input  logic         sub_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         cout_o
);
  localparam int WW = 2 * W;

  logic [WW-1:0] pair;
  logic [WW-1:0] k;
  logic [WW:0]   ext;

  assign pair = {hi_i, lo_i};
  assign k    = {{(WW-IMM_W){1'b0}}, imm_i[IMM_W-1:0]};

  always_comb begin
    if (sub_i) ext = {1'b0, pair} - {1'b0, k};
    else       ext = {1'b0, pair} + {1'b0, k};
  end

  assign {hi_o, lo_o} = ext[WW-1:0];
  assign cout_o       = ext[WW];

  always_comb begin
    if (!$isunknown({lo_i, hi_i, imm_i, sub_i})) begin
      a_r9_word_order: assert (cout_o == (sub_i ? ({hi_o, lo_o} > pair) : ({hi_o, lo_o} < pair)))
        else $error("pair carry inconsistent with result order");
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIMM_W = 6
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] a_hi_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              use_imm_i,
  input  logic              carry_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] result_hi_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              wr_en_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  alu_grp_e          grp;
  logic [DATA_W-1:0] s_opnd;
  logic [DATA_W-1:0] ax, ay, a_sum;
  logic              a_cin, a_sub, a_cout;
  logic [DATA_W-1:0] l_res;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic [DATA_W-1:0] w_lo, w_hi;
  logic              w_cout;

  assign grp    = op_group(op_i);
  assign s_opnd = use_imm_i ? imm_i : b_i;

  always_comb begin
    ax    = a_i;
    ay    = s_opnd;
    a_cin = 1'b0;
    a_sub = 1'b0;
    case (op_i)
      OP_ADC:         a_cin = carry_i;
      OP_SUB, OP_CP:  a_sub = 1'b1;
      OP_SBC, OP_CPC: begin a_sub = 1'b1; a_cin = carry_i; end
      OP_COM:         begin ax = '1; ay = a_i; a_sub = 1'b1; end
      OP_NEG:         begin ax = '0; ay = a_i; a_sub = 1'b1; end
      OP_INC:         ay = ONE;
      OP_DEC:         begin ay = ONE; a_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .x_i(ax), .y_i(ay), .cin_i(a_cin), .sub_i(a_sub),
    .sum_o(a_sum), .cout_o(a_cout)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .op_i(op_i), .a_i(a_i), .s_i(s_opnd), .res_o(l_res)
  );

  alu8_shift #(.W(DATA_W)) u_shift (
    .op_i(op_i), .a_i(a_i), .cin_i(carry_i), .res_o(sh_res), .cout_o(sh_cout)
  );

  alu8_word #(.W(DATA_W), .IMM_W(WIMM_W)) u_word (
    .lo_i(a_i), .hi_i(a_hi_i), .imm_i(imm_i), .sub_i(op_i == OP_SBW),
    .lo_o(w_lo), .hi_o(w_hi), .cout_o(w_cout)
  );

  always_comb begin
    result_o    = a_i;
    result_hi_o = a_hi_i;
    carry_o     = carry_i;
    wr_en_o     = 1'b1;
    case (grp)
      GRP_ARITH: begin result_o = a_sum; carry_o = a_cout; end
      GRP_STEP:  result_o = a_sum;
      GRP_LOGIC: result_o = l_res;
      GRP_SHIFT: begin result_o = sh_res; carry_o = sh_cout; end
      GRP_WORD:  begin result_o = w_lo; result_hi_o = w_hi; carry_o = w_cout; end
      default:   wr_en_o = 1'b0;
    endcase
    if (op_i == OP_CP || op_i == OP_CPC) wr_en_o = 1'b0;
  end

  always_comb begin
    if (grp == GRP_WORD) begin
      zero_o = ({result_hi_o, result_o} == '0);
      neg_o  = result_hi_o[DATA_W-1];
    end else begin
      zero_o = (result_o == '0);
      neg_o  = result_o[DATA_W-1];
    end
  end

  always_comb begin
    if (!$isunknown({a_i, a_hi_i, b_i, imm_i, use_imm_i, carry_i, op_i})) begin
      if (grp != GRP_WORD) begin
        a_r12_hi_passthru: assert (result_hi_o == a_hi_i)
          else $error("byte op disturbed high byte");
      end
      if (grp == GRP_LOGIC || grp == GRP_STEP) begin
        a_r6_carry_hold: assert (carry_o == carry_i)
          else $error("carry changed by non-arith op");
      end
      if (op_i == OP_NEG) begin
        a_r4_neg_carry: assert (carry_o == (a_i != '0) && DATA_W'(result_o + a_i) == '0)
          else $error("negate result or carry wrong");
      end
      if (op_i == OP_CP || op_i == OP_CPC) begin
        a_r10_no_write: assert (!wr_en_o)
          else $error("compare requested write");
      end
    end
  end
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, a_hi_i = '0, b_i = '0, imm_i = '0;
  logic       use_imm_i = 1'b0, carry_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] result_o, result_hi_o;
  logic       carry_o, zero_o, neg_o, wr_en_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_core uut (
    .a_i(a_i), .a_hi_i(a_hi_i), .b_i(b_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
    .carry_i(carry_i), .op_i(op_i), .result_o(result_o), .result_hi_o(result_hi_o),
    .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o), .wr_en_o(wr_en_o)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      7, 8: return "R4";
      4, 5, 6, 9, 10: return "R5";
      13, 14, 15: return "R6";
      11, 12: return "R7";
      16, 17, 18, 19, 20: return "R8";
      21, 22: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model written from the requirements
  task automatic model(input int op, input int a, input int ah, input int b, input int im,
                       input int ui, input int c,
                       output int r, output int rh, output int co, output int z,
                       output int n, output int we);
    int s, w;
    s = ui != 0 ? im : b;
    r = a; rh = ah; co = c; we = 1; w = 0;
    case (op)
      0: begin w = a + s;     r = w & 255; co = w >> 8; end
      1: begin w = a + s + c; r = w & 255; co = w >> 8; end
      2, 23: begin r = (a - s + 256) & 255; co = (a < s) ? 1 : 0; end
      3, 24: begin r = (a - s - c + 512) & 255; co = (a < s + c) ? 1 : 0; end
      4: r = a & s;
      5, 9: r = a | s;
      6: r = a ^ s;
      7: begin r = 255 - a; co = 0; end
      8: begin r = (256 - a) & 255; co = (a != 0) ? 1 : 0; end
      10: r = a & (255 - s);
      11: r = (a + 1) & 255;
      12: r = (a + 255) & 255;
      13: r = a;
      14: r = 0;
      15: r = 255;
      16: begin r = (a << 1) & 255; co = a >> 7; end
      17: begin r = a >> 1; co = a & 1; end
      18: begin r = ((a << 1) | c) & 255; co = a >> 7; end
      19: begin r = (c << 7) | (a >> 1); co = a & 1; end
      20: begin r = (a & 128) | (a >> 1); co = a & 1; end
      21: begin w = ah * 256 + a + (im & 63); co = w >> 16; w = w & 65535; end
      22: begin w = ah * 256 + a - (im & 63); co = (w < 0) ? 1 : 0; w = (w + 65536) & 65535; end
      default: ;
    endcase
    if (op == 21 || op == 22) begin
      r = w & 255; rh = w >> 8; z = (w == 0) ? 1 : 0; n = (w >> 15) & 1;
    end else begin
      z = (r == 0) ? 1 : 0; n = (r >> 7) & 1;
    end
    if (op == 23 || op == 24) we = 0;
  endtask

  task automatic apply_check(input int op, input int a, input int ah, input int b,
                             input int im, input int ui, input int c, input string why);
    int r, rh, co, z, n, we;
    logic [27:0] got, exp;
    op_i = 5'(op); a_i = 8'(a); a_hi_i = 8'(ah); b_i = 8'(b); imm_i = 8'(im);
    use_imm_i = 1'(ui); carry_i = 1'(c);
    @(negedge clk);
    model(op, a, ah, b, im, ui, c, r, rh, co, z, n, we);
    got = {result_hi_o, result_o, carry_o, zero_o, neg_o, wr_en_o, 8'h0};
    exp = {8'(rh), 8'(r), 1'(co), 1'(z), 1'(n), 1'(we), 8'h0};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h ah=%02h b=%02h imm=%02h ui=%0d c=%0d %s: got hi/res/c/z/n/we=%02h/%02h/%b%b%b%b exp=%02h/%02h/%b%b%b%b",
               (why != "") ? why : tag_of(op), op, a, ah, b, im, ui, c, tag_of(op),
               got[27:20], got[19:12], got[11], got[10], got[9], got[8],
               exp[27:20], exp[19:12], exp[11], exp[10], exp[9], exp[8]);
    end
  endtask

  // {op, a, b, c, expected result, expected carry}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},  // R1 wrap
    {5'd1,  8'h7F, 8'h00, 1'b1, 8'h80, 1'b0},  // R1 carry-in
    {5'd2,  8'h00, 8'h01, 1'b0, 8'hFF, 1'b1},  // R2 borrow
    {5'd3,  8'h01, 8'h01, 1'b1, 8'hFF, 1'b1},  // R2 borrow via carry
    {5'd7,  8'h5A, 8'h00, 1'b1, 8'hA5, 1'b0},  // R4
    {5'd8,  8'h80, 8'h00, 1'b0, 8'h80, 1'b1},  // R4
    {5'd8,  8'h00, 8'h00, 1'b1, 8'h00, 1'b0},  // R4 zero negate
    {5'd10, 8'hFF, 8'h0F, 1'b1, 8'hF0, 1'b1},  // R5
    {5'd12, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1},  // R7 carry untouched
    {5'd18, 8'h80, 8'h00, 1'b1, 8'h01, 1'b1},  // R8
    {5'd19, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1},  // R8
    {5'd20, 8'h81, 8'h00, 1'b0, 8'hC0, 1'b1}   // R8
  };

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int edges[4];
    edges = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // reset state: all-zero inputs give ADD of zeros (R11)
    apply_check(0, 0, 0, 0, 0, 0, 0, "R11 idle");

    for (int i = 0; i < NV; i++) begin
      int r, rh, co, z, n, we;
      op_i = VEC[i][30:26]; a_i = VEC[i][25:18]; b_i = VEC[i][17:10]; carry_i = VEC[i][9];
      a_hi_i = 8'h3C; imm_i = 8'h00; use_imm_i = 1'b0;
      @(negedge clk);
      n_run++;
      if (result_o !== VEC[i][8:1] || carry_o !== VEC[i][0]) begin
        n_fail++;
        $display("FAIL %s vector %0d: got %02h/%b exp %02h/%b", tag_of(int'(VEC[i][30:26])),
                 i, result_o, carry_o, VEC[i][8:1], VEC[i][0]);
      end
      model(int'(op_i), int'(a_i), 8'h3C, int'(b_i), 0, 0, int'(carry_i), r, rh, co, z, n, we);
    end

    // edge sweep over all ops, both operand sources (R3), both carries
    for (int op = 0; op < 25; op++)
      for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
          for (int c = 0; c < 2; c++)
            for (int ui = 0; ui < 2; ui++)
              apply_check(op, edges[ia], edges[3 - ib], edges[ib], 255 - edges[ib], ui, c,
                          (ui != 0) ? "R3" : "");

    // pair boundary cases R9
    apply_check(21, 8'hFF, 8'h00, 0, 8'h01, 0, 0, "R9 byte carry");
    apply_check(21, 8'hC1, 8'hFF, 0, 8'h3F, 0, 0, "R9 wrap to zero");
    apply_check(22, 8'h00, 8'h00, 0, 8'h01, 0, 1, "R9 borrow");
    apply_check(22, 8'h00, 8'h01, 0, 8'hC1, 0, 0, "R9 imm low bits");

    // R12 and R11 with varied high byte
    apply_check(6, 8'hAA, 8'h55, 8'hAA, 0, 0, 0, "R12 hi kept");
    apply_check(14, 8'h12, 8'h99, 0, 0, 0, 1, "R11 zero flag");

    // random operands
    for (int k = 0; k < 600; k++)
      apply_check(int'($urandom_range(24)), int'($urandom_range(255)), int'($urandom_range(255)),
                  int'($urandom_range(255)), int'($urandom_range(255)),
                  int'($urandom_range(1)), int'($urandom_range(1)), "");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule